// File: doc/BRIEF.md
# Nibble-Tagged Register Access Port

This block decodes a stream of command bytes from a host link and turns them into accesses to an 8-bit register file. Each command byte splits into two halves. The upper four bits select an operation and the lower four bits carry a payload. The port keeps an internal address pointer. It assembles that pointer from two address commands, low half first. It assembles a write byte from two data commands, and the register write happens on the second of them.

A read command takes the byte at the pointer and holds it on a response output until the host accepts it. A flag bit in the read command steps the pointer afterwards, so a run of such reads returns a multi-byte field one byte at a time, least significant byte first. Writes also step the pointer, so a burst of data pairs fills consecutive registers.

The register file is outside the block. It presents the byte at `reg_addr` without delay on `reg_rd_data`, and it takes one write per cycle in which `reg_wr_en` is high.

Top module: `nib_reg_port`

## Requirements
- R1: After reset the pointer is 0x00, no write is issued, no response is pending, `cmd_ready` is high, and the held low data nibble is zero.
- R2: Opcode 0x0 loads the payload into pointer bits [3:0] and leaves bits [7:4] unchanged.
- R3: Opcode 0x1 loads the payload into pointer bits [7:4] and leaves bits [3:0] unchanged.
- R4: Opcode 0x2 stores the payload as the low data nibble. It issues no write and does not move the pointer.
- R5: Opcode 0x3 issues exactly one write, in the cycle after it is accepted. The write address is the pointer and the write data is {payload, held low nibble}.
- R6: Every write advances the pointer by one, wrapping from 0xFF to 0x00, so repeated data pairs land in consecutive registers.
- R7: Opcode 0x4 with payload bit 0 clear returns the byte at the pointer on `rsp_data`, with `rsp_valid` high from the next cycle. The pointer is unchanged.
- R8: Opcode 0x4 with payload bit 0 set returns the byte at the pointer and then advances the pointer by one. Six such reads return two 24-bit fields, least significant byte first.
- R9: While `rsp_valid` is high, `cmd_ready` is low, and `rsp_data` stays stable until `rsp_ready` is seen.
- R10: Opcodes 0x5 to 0xF are accepted and ignored. They issue no write, produce no response and leave the pointer unchanged.
- R11: The low data nibble persists after a write. A second opcode 0x3 without a new opcode 0x2 reuses it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command byte present |
| cmd_ready | output | 1 | Port can take a command |
| cmd_byte | input | 8 | Opcode in [7:4], payload in [3:0] |
| reg_addr | output | 8 | Current pointer, used as read address |
| reg_rd_data | input | 8 | Register file byte at `reg_addr` |
| reg_wr_en | output | 1 | One-cycle write strobe |
| reg_wr_addr | output | 8 | Write address |
| reg_wr_data | output | 8 | Write data |
| rsp_valid | output | 1 | Read byte pending |
| rsp_ready | input | 1 | Host takes the read byte |
| rsp_data | output | 8 | Read byte |

## Verification
The bench writes all 256 registers in one burst and then reads them back with stepping reads. This covers the pointer wrap at 0xFF. A design that stopped at the top of the map, or that did not advance the pointer after a write, would read back the wrong values. A write-data command sent straight after reset exposes a low nibble that was not cleared. Two write-data commands in a row expose a nibble that was dropped after the first write. The bench also holds `rsp_ready` low with a command waiting. A port that did not stall would take the command and overwrite the pending byte. Unused opcodes are swept with several payloads. A decoder that only compared some of the opcode bits would write registers or move the pointer on them.

// File: rtl/nrp_pkg.sv
package nrp_pkg;

  typedef enum logic [3:0] {
    OP_ADDR_LO = 4'h0,
    OP_ADDR_HI = 4'h1,
    OP_DATA_LO = 4'h2,
    OP_DATA_WR = 4'h3,
    OP_READ    = 4'h4
  } nrp_op_e;

  typedef struct packed {
    logic ld_lo;
    logic ld_hi;
    logic dat_lo;
    logic wr;
    logic rd;
    logic step;
  } nrp_strb_t;

endpackage

// File: rtl/nrp_cmd_decode.sv
module nrp_cmd_decode
  import nrp_pkg::*;
#(
  parameter int NIB_W = 4
) (
  input  logic             accept,
  input  logic [NIB_W-1:0] opcode,
  input  logic             nxt_flag,
  output nrp_strb_t        strb
);

  function automatic logic is_op(logic [NIB_W-1:0] op, nrp_op_e code);
    return op == NIB_W'(code);
  endfunction

  always_comb begin
    strb        = '0;
    strb.ld_lo  = accept && is_op(opcode, OP_ADDR_LO);
    strb.ld_hi  = accept && is_op(opcode, OP_ADDR_HI);
    strb.dat_lo = accept && is_op(opcode, OP_DATA_LO);
    strb.wr     = accept && is_op(opcode, OP_DATA_WR);
    strb.rd     = accept && is_op(opcode, OP_READ);
    strb.step   = strb.wr || (strb.rd && nxt_flag);
  end

endmodule

// File: rtl/nrp_addr_ptr.sv
module nrp_addr_ptr #(
  parameter int NIB_W = 4,
  localparam int ADDR_W = 2 * NIB_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_lo,
  input  logic              ld_hi,
  input  logic              step,
  input  logic [NIB_W-1:0]  payload,
  output logic [ADDR_W-1:0] ptr
);

  function automatic logic [ADDR_W-1:0] bump(logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction

  logic [1:0]        lane_ld;
  logic [ADDR_W-1:0] ptr_nxt;

  assign lane_ld = {ld_hi, ld_lo};

  always_comb begin
    ptr_nxt = step ? bump(ptr) : ptr;
    for (int g = 0; g < 2; g++) begin
      if (lane_ld[g]) ptr_nxt[g*NIB_W +: NIB_W] = payload;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr <= '0;
    else        ptr <= ptr_nxt;
  end

endmodule

// File: rtl/nrp_wr_assemble.sv
module nrp_wr_assemble #(
  parameter int NIB_W = 4,
  localparam int W = 2 * NIB_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dat_lo,
  input  logic             wr,
  input  logic [NIB_W-1:0] payload,
  input  logic [W-1:0]     ptr,
  output logic             wr_en,
  output logic [W-1:0]     wr_addr,
  output logic [W-1:0]     wr_data
);

  logic [NIB_W-1:0] lo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q    <= '0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= wr;
      if (dat_lo) lo_q <= payload;
      if (wr) begin
        wr_addr <= ptr;
        wr_data <= {payload, lo_q};
      end
    end
  end

endmodule

// File: rtl/nrp_rsp_slot.sv
module nrp_rsp_slot #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         rsp_ready,
  output logic         rsp_valid,
  output logic [W-1:0] rsp_data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (load) begin
      rsp_valid <= 1'b1;
      rsp_data  <= din;
    end else if (rsp_valid && rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/nib_reg_port.sv
module nib_reg_port
  import nrp_pkg::*;
#(
  parameter int NIB_W = 4,
  localparam int W = 2 * NIB_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmd_valid,
  output logic         cmd_ready,
  input  logic [W-1:0] cmd_byte,
  output logic [W-1:0] reg_addr,
  input  logic [W-1:0] reg_rd_data,
  output logic         reg_wr_en,
  output logic [W-1:0] reg_wr_addr,
  output logic [W-1:0] reg_wr_data,
  output logic         rsp_valid,
  input  logic         rsp_ready,
  output logic [W-1:0] rsp_data
);

  logic             cmd_accept;
  logic [NIB_W-1:0] cmd_op;
  logic [NIB_W-1:0] cmd_pay;
  nrp_strb_t        strb;

  assign cmd_ready  = !rsp_valid;
  assign cmd_accept = cmd_valid && cmd_ready;
  assign cmd_op     = cmd_byte[W-1:NIB_W];
  assign cmd_pay    = cmd_byte[NIB_W-1:0];

  nrp_cmd_decode #(.NIB_W(NIB_W)) u_dec (
    .accept   (cmd_accept),
    .opcode   (cmd_op),
    .nxt_flag (cmd_pay[0]),
    .strb     (strb)
  );

  nrp_addr_ptr #(.NIB_W(NIB_W)) u_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_lo   (strb.ld_lo),
    .ld_hi   (strb.ld_hi),
    .step    (strb.step),
    .payload (cmd_pay),
    .ptr     (reg_addr)
  );

  nrp_wr_assemble #(.NIB_W(NIB_W)) u_wr (
    .clk     (clk),
    .rst_n   (rst_n),
    .dat_lo  (strb.dat_lo),
    .wr      (strb.wr),
    .payload (cmd_pay),
    .ptr     (reg_addr),
    .wr_en   (reg_wr_en),
    .wr_addr (reg_wr_addr),
    .wr_data (reg_wr_data)
  );

  nrp_rsp_slot #(.W(W)) u_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (strb.rd),
    .din       (reg_rd_data),
    .rsp_ready (rsp_ready),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data)
  );

endmodule

// File: rtl/nrp_checks.sv
module nrp_checks #(
  parameter int NIB_W = 4,
  localparam int W = 2 * NIB_W
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cmd_accept,
  input logic         cmd_ready,
  input logic [W-1:0] cmd_byte,
  input logic [W-1:0] reg_addr,
  input logic [W-1:0] reg_rd_data,
  input logic         reg_wr_en,
  input logic [W-1:0] reg_wr_addr,
  input logic [W-1:0] reg_wr_data,
  input logic         rsp_valid,
  input logic         rsp_ready,
  input logic [W-1:0] rsp_data
);

  logic [NIB_W-1:0] op;
  assign op = cmd_byte[W-1:NIB_W];

  p_addr_lo_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_accept && op == NIB_W'(0) |=>
      reg_addr[NIB_W-1:0] == $past(cmd_byte[NIB_W-1:0]) &&
      reg_addr[W-1:NIB_W] == $past(reg_addr[W-1:NIB_W]));

  p_addr_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_accept && op == NIB_W'(1) |=>
      reg_addr[W-1:NIB_W] == $past(cmd_byte[NIB_W-1:0]) &&
      reg_addr[NIB_W-1:0] == $past(reg_addr[NIB_W-1:0]));

  p_data_lo_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_accept && op == NIB_W'(2) |=> !reg_wr_en && $stable(reg_addr));

  p_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_accept && op == NIB_W'(3) |=>
      reg_wr_en && reg_wr_addr == $past(reg_addr) &&
      reg_wr_data[W-1:NIB_W] == $past(cmd_byte[NIB_W-1:0]));

  p_write_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_accept && op == NIB_W'(3) |=> reg_addr == $past(reg_addr) + W'(1));

  p_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_accept && op == NIB_W'(4) |=> rsp_valid && rsp_data == $past(reg_rd_data));

  p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !cmd_ready);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));

  p_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_accept && op > NIB_W'(4) |=> !reg_wr_en && !rsp_valid && $stable(reg_addr));

endmodule

bind nib_reg_port nrp_checks #(.NIB_W(NIB_W)) u_nrp_checks (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_accept  (cmd_accept),
  .cmd_ready   (cmd_ready),
  .cmd_byte    (cmd_byte),
  .reg_addr    (reg_addr),
  .reg_rd_data (reg_rd_data),
  .reg_wr_en   (reg_wr_en),
  .reg_wr_addr (reg_wr_addr),
  .reg_wr_data (reg_wr_data),
  .rsp_valid   (rsp_valid),
  .rsp_ready   (rsp_ready),
  .rsp_data    (rsp_data)
);

// File: tb/tb_nib_reg_port.sv
module tb_nib_reg_port;

  localparam int NREG = 256;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic       cmd_ready;
  logic [7:0] cmd_byte = 8'h00;
  logic [7:0] reg_addr;
  logic [7:0] reg_rd_data;
  logic       reg_wr_en;
  logic [7:0] reg_wr_addr;
  logic [7:0] reg_wr_data;
  logic       rsp_valid;
  logic       rsp_ready = 1'b1;
  logic [7:0] rsp_data;

  logic [7:0] mem [NREG];
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  always_ff @(posedge clk) if (reg_wr_en) mem[reg_wr_addr] <= reg_wr_data;
  assign reg_rd_data = mem[reg_addr];

  nib_reg_port dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_byte(cmd_byte), .reg_addr(reg_addr), .reg_rd_data(reg_rd_data),
    .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data)
  );

  function automatic logic [7:0] pattern(int i);
    return 8'((i * 37 + 11) % 256);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(logic [7:0] b);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1;
    cmd_byte  = b;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic set_addr(logic [7:0] a);
    send({4'h0, a[3:0]});
    send({4'h1, a[7:4]});
  endtask

  task automatic rd(bit nxt, output logic [7:0] v);
    send({7'h20, nxt});
    chk("R7 rsp_valid", 32'(rsp_valid), 32'd1);
    v = rsp_data;
  endtask

  initial begin
    logic [7:0] v, v2, lo, held;
    logic [23:0] trig, stp;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 addr", 32'(reg_addr), 32'h0);
    chk("R1 rsp_valid", 32'(rsp_valid), 32'd0);
    chk("R1 wr_en", 32'(reg_wr_en), 32'd0);
    chk("R1 cmd_ready", 32'(cmd_ready), 32'd1);
    send(8'h3A);
    chk("R1 cleared low nibble", 32'(reg_wr_data), 32'hA0);
    chk("R5 write addr after reset", 32'(reg_wr_addr), 32'h0);

    // R2 R3: address halves independent
    set_addr(8'h5C);
    chk("R3 addr", 32'(reg_addr), 32'h5C);
    send(8'h07);
    chk("R2 low only", 32'(reg_addr), 32'h57);
    send(8'h1E);
    chk("R3 high only", 32'(reg_addr), 32'hE7);

    // R4 R5 R6: burst over whole map
    set_addr(8'h00);
    for (int i = 0; i < NREG; i++) begin
      send({4'h2, pattern(i)[3:0]});
      chk("R4 no write", 32'(reg_wr_en), 32'd0);
      send({4'h3, pattern(i)[7:4]});
      chk("R5 wr_en", 32'(reg_wr_en), 32'd1);
      chk("R6 wr_addr", 32'(reg_wr_addr), 32'(i));
      chk("R5 wr_data", 32'(reg_wr_data), 32'(pattern(i)));
    end
    chk("R6 wrap to 0", 32'(reg_addr), 32'h0);
    @(negedge clk);
    chk("R5 single pulse", 32'(reg_wr_en), 32'd0);

    // R8 full readback with stepping reads
    for (int i = 0; i < NREG; i++) begin
      rd(1'b1, v);
      chk("R8 readback", 32'(v), 32'(pattern(i)));
    end
    chk("R8 wrap", 32'(reg_addr), 32'h0);

    // R7 non-stepping
    set_addr(8'h42);
    rd(1'b0, v);
    rd(1'b0, v2);
    chk("R7 value", 32'(v), 32'(pattern(8'h42)));
    chk("R7 repeat", 32'(v2), 32'(pattern(8'h42)));
    chk("R7 ptr held", 32'(reg_addr), 32'h42);

    // R8 two 24-bit fields
    set_addr(8'h10);
    trig = '0; stp = '0;
    for (int k = 0; k < 3; k++) begin rd(1'b1, v); trig[k*8 +: 8] = v; end
    for (int k = 0; k < 3; k++) begin rd(1'b1, v); stp[k*8 +: 8] = v; end
    chk("R8 first field", 32'(trig),
        32'({pattern(8'h12), pattern(8'h11), pattern(8'h10)}));
    chk("R8 second field", 32'(stp),
        32'({pattern(8'h15), pattern(8'h14), pattern(8'h13)}));
    chk("R8 ptr", 32'(reg_addr), 32'h16);

    // R11 low nibble reuse
    set_addr(8'h80);
    send(8'h26);
    send(8'h3B);
    chk("R11 first", 32'(reg_wr_data), 32'hB6);
    send(8'h3C);
    chk("R11 reuse", 32'(reg_wr_data), 32'hC6);
    chk("R11 addr", 32'(reg_wr_addr), 32'h81);

    // R9 stall
    set_addr(8'h20);
    rsp_ready = 1'b0;
    rd(1'b0, held);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_byte  = 8'h3F;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R9 cmd_ready low", 32'(cmd_ready), 32'd0);
      chk("R9 data held", 32'(rsp_data), 32'(held));
      chk("R9 no write", 32'(reg_wr_en), 32'd0);
    end
    chk("R9 held value", 32'(held), 32'(pattern(8'h20)));
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R9 released", 32'(rsp_valid), 32'd0);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R9 queued write", 32'(reg_wr_en), 32'd1);
    chk("R9 queued addr", 32'(reg_wr_addr), 32'h20);
    lo = 8'h06;
    chk("R9 queued data", 32'(reg_wr_data), 32'({4'hF, lo[3:0]}));

    // R10 unused opcodes
    set_addr(8'h33);
    for (int op = 5; op < 16; op++) begin
      for (int p = 0; p < 16; p += 5) begin
        send(8'((op << 4) | p));
        chk("R10 no write", 32'(reg_wr_en), 32'd0);
        chk("R10 no rsp", 32'(rsp_valid), 32'd0);
        chk("R10 addr", 32'(reg_addr), 32'h33);
      end
    end
    rd(1'b0, v);
    chk("R10 reg intact", 32'(v), 32'(pattern(8'h33)));

    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule